// File: doc/BRIEF.md
# Two-Step Sync / Follow-Up Pairing Checker

This block sits on the receive side of a slave port whose master runs two-step synchronization. The Sync event message reaches it first, already decoded, together with the local ingress timestamp (t2) captured at the wire. The precise origin time (t1) arrives later in a Follow_Up message. The block holds the Sync as pending. It releases a pair to the clock servo only when a Follow_Up arrives that carries the same sequenceId and the same source port identity, and arrives within a programmable window counted in clock cycles.

Every other outcome is dropped and counted: a Sync that another Sync overwrites, a Sync whose Follow_Up never comes in time, and a Follow_Up with no matching pending Sync. Dropped Follow_Ups are also sorted into late ones (identity of the last expired Sync) and duplicate ones (identity of the last paired Sync). On each pair the block reports the Sync-to-Follow_Up gap. It keeps the largest gap seen and counts breaks in sequenceId continuity between successive pairs. These records show the arrival distribution and the pairing continuity that explain periodic offset jumps.

Top module: `ptp_fup_pairer`

## Requirements
- R1: When `fup_valid` is sampled with `fup_seq` and `fup_port` equal to the pending Sync, `pair_valid` is high for the following cycle. In that cycle `pair_t1` is the Follow_Up origin time, `pair_t2` is the Sync ingress time and `pair_seq` is the sequenceId.
- R2: `pair_corr` is the sum, modulo 2^64, of the Sync and Follow_Up correction values. Both are in nanoseconds scaled by 2^16.
- R3: A Follow_Up that does not pair produces no `pair_valid`. It raises `evt_mismatch` for one cycle, and `mismatch_cnt` rises by one a cycle later. Among these, `evt_late` marks a Follow_Up whose sequenceId and port equal the last expired Sync. `evt_dup` marks one whose sequenceId and port equal the last paired Sync.
- R4: A Sync sampled while another is pending and unresolved replaces it. It raises `evt_lost`, and `lost_cnt` rises by one.
- R5: A pending Sync is discarded at the clock edge where its age reaches `timeout_cycles` with no matching Follow_Up. That edge raises `evt_timeout` and adds one to `timeout_cnt`. A Follow_Up sampled exactly `timeout_cycles` edges after its Sync still pairs.
- R6: `pair_gap` equals the number of clock edges from the edge that sampled the Sync to the edge that sampled its Follow_Up. `max_gap` holds the largest `pair_gap` since reset.
- R7: `discont_cnt` rises by one when a pair's sequenceId is not the previous pair's sequenceId plus one, modulo 2^16. The first pair after reset never counts. A step from 65535 to 0 is continuous.
- R8: When a Sync and a Follow_Up are sampled at the same edge, the Follow_Up is matched against the Sync that was already pending. The new Sync then becomes pending, and no loss is counted if the old one paired.
- R9: After reset, `pending`, `pair_valid`, all event flags, all counters and `max_gap` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timeout_cycles | input | TMO_W | Pairing window in clock cycles |
| sync_valid | input | 1 | Decoded Sync event present |
| sync_seq | input | SEQ_W | Sync sequenceId |
| sync_port | input | PORT_W | Sync source port identity |
| sync_ts | input | TS_W | Local ingress timestamp t2 |
| sync_corr | input | CORR_W | Sync correction value |
| fup_valid | input | 1 | Decoded Follow_Up present |
| fup_seq | input | SEQ_W | Follow_Up sequenceId |
| fup_port | input | PORT_W | Follow_Up source port identity |
| fup_t1 | input | TS_W | Precise origin time t1 |
| fup_corr | input | CORR_W | Follow_Up correction value |
| pair_valid | output | 1 | Paired tuple strobe |
| pair_seq | output | SEQ_W | SequenceId of the pair |
| pair_t1 | output | TS_W | Origin time t1 |
| pair_t2 | output | TS_W | Ingress time t2 |
| pair_corr | output | CORR_W | Summed correction |
| pair_gap | output | TMO_W | Sync-to-Follow_Up gap in cycles |
| pending | output | 1 | A Sync awaits its Follow_Up |
| evt_lost | output | 1 | Pending Sync overwritten |
| evt_timeout | output | 1 | Pending Sync expired |
| evt_mismatch | output | 1 | Follow_Up dropped |
| evt_late | output | 1 | Dropped Follow_Up belonged to the expired Sync |
| evt_dup | output | 1 | Dropped Follow_Up repeated the last pair |
| lost_cnt | output | CNT_W | Saturating count of overwritten Syncs |
| timeout_cnt | output | CNT_W | Saturating count of expired Syncs |
| mismatch_cnt | output | CNT_W | Saturating count of dropped Follow_Ups |
| discont_cnt | output | CNT_W | Saturating count of sequence breaks |
| max_gap | output | TMO_W | Largest pair gap seen |

## Verification
A corrupted pending slot shows at the ports within one cycle of the next Follow_Up. A wrong stored identity turns an expected `pair_valid` into `evt_mismatch`, and a wrong stored timestamp or correction changes `pair_t2` or `pair_corr` in that same strobe. A faulty age counter shows as a `pair_gap` that differs from the bench's edge count, or as an expiry one cycle early or late at the window boundary. The bench probes that boundary with gaps equal to and one past `timeout_cycles`. Faults in the continuity or loss state show one cycle after the triggering pair or Sync, in `discont_cnt` or `lost_cnt`.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    // how an incoming Follow_Up relates to the held state
    typedef enum logic [1:0] {
        FUP_STRAY = 2'd0,
        FUP_MATCH = 2'd1,
        FUP_LATE  = 2'd2,
        FUP_DUP   = 2'd3
    } fup_class_e;

    // event lanes feeding the statistics counters
    localparam int EV_LOST = 0;
    localparam int EV_TMO  = 1;
    localparam int EV_MIS  = 2;
    localparam int EV_DISC = 3;
    localparam int NUM_EV  = 4;

endpackage

// File: rtl/sfp_classify.sv
module sfp_classify
    import sfp_pkg::*;
#(
    parameter int SEQ_W  = 16,
    parameter int PORT_W = 80
) (
    input  logic [SEQ_W-1:0]  fup_seq,
    input  logic [PORT_W-1:0] fup_port,
    input  logic              pend_v,
    input  logic [SEQ_W-1:0]  pend_seq,
    input  logic [PORT_W-1:0] pend_port,
    input  logic              exp_v,
    input  logic [SEQ_W-1:0]  exp_seq,
    input  logic [PORT_W-1:0] exp_port,
    input  logic              done_v,
    input  logic [SEQ_W-1:0]  done_seq,
    input  logic [PORT_W-1:0] done_port,
    output fup_class_e        cls
);

    logic hit_pend, hit_exp, hit_done;

    always_comb begin
        hit_pend = pend_v && (fup_seq == pend_seq) && (fup_port == pend_port);
        hit_exp  = exp_v  && (fup_seq == exp_seq)  && (fup_port == exp_port);
        hit_done = done_v && (fup_seq == done_seq) && (fup_port == done_port);
        // a live pending Sync always wins over history
        if (hit_pend)      cls = FUP_MATCH;
        else if (hit_exp)  cls = FUP_LATE;
        else if (hit_done) cls = FUP_DUP;
        else               cls = FUP_STRAY;
    end

endmodule

// File: rtl/sfp_slot.sv
module sfp_slot
    import sfp_pkg::*;
#(
    parameter int SEQ_W  = 16,
    parameter int PORT_W = 80,
    parameter int TS_W   = 80,
    parameter int CORR_W = 64,
    parameter int TMO_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMO_W-1:0]  timeout_cycles,
    input  logic              sync_valid,
    input  logic [SEQ_W-1:0]  sync_seq,
    input  logic [PORT_W-1:0] sync_port,
    input  logic [TS_W-1:0]   sync_ts,
    input  logic [CORR_W-1:0] sync_corr,
    input  logic              fup_valid,
    input  logic [TS_W-1:0]   fup_t1,
    input  logic [CORR_W-1:0] fup_corr,
    input  fup_class_e        fup_cls,
    output logic              pend_v,
    output logic [SEQ_W-1:0]  pend_seq,
    output logic [PORT_W-1:0] pend_port,
    output logic              exp_v,
    output logic [SEQ_W-1:0]  exp_seq,
    output logic [PORT_W-1:0] exp_port,
    output logic              done_v,
    output logic [SEQ_W-1:0]  done_seq,
    output logic [PORT_W-1:0] done_port,
    output logic              pair_v,
    output logic [SEQ_W-1:0]  pair_seq,
    output logic [TS_W-1:0]   pair_t1,
    output logic [TS_W-1:0]   pair_t2,
    output logic [CORR_W-1:0] pair_corr,
    output logic [TMO_W-1:0]  pair_gap,
    output logic              ev_lost,
    output logic              ev_tmo,
    output logic              ev_mis,
    output logic              ev_late,
    output logic              ev_dup
);

    typedef struct packed {
        logic              pend_v;
        logic [SEQ_W-1:0]  pend_seq;
        logic [PORT_W-1:0] pend_port;
        logic [TS_W-1:0]   pend_ts;
        logic [CORR_W-1:0] pend_corr;
        logic [TMO_W-1:0]  age;
        logic              exp_v;
        logic [SEQ_W-1:0]  exp_seq;
        logic [PORT_W-1:0] exp_port;
        logic              done_v;
        logic [SEQ_W-1:0]  done_seq;
        logic [PORT_W-1:0] done_port;
        logic              pair_v;
        logic [SEQ_W-1:0]  pair_seq;
        logic [TS_W-1:0]   pair_t1;
        logic [TS_W-1:0]   pair_t2;
        logic [CORR_W-1:0] pair_corr;
        logic [TMO_W-1:0]  pair_gap;
        logic              ev_lost;
        logic              ev_tmo;
        logic              ev_mis;
        logic              ev_late;
        logic              ev_dup;
    } slot_t;

    slot_t st_d, st_q;
    logic  matched, expired;

    always_comb begin
        st_d         = st_q;
        st_d.pair_v  = 1'b0;
        st_d.ev_lost = 1'b0;
        st_d.ev_tmo  = 1'b0;
        st_d.ev_mis  = 1'b0;
        st_d.ev_late = 1'b0;
        st_d.ev_dup  = 1'b0;
        matched      = 1'b0;
        expired      = 1'b0;

        if (st_q.pend_v) begin
            st_d.age = st_q.age + 1'b1;
        end

        // Follow_Up is resolved against the Sync held before this edge
        if (fup_valid) begin
            if (fup_cls == FUP_MATCH) begin
                matched        = 1'b1;
                st_d.pend_v    = 1'b0;
                st_d.pair_v    = 1'b1;
                st_d.pair_seq  = st_q.pend_seq;
                st_d.pair_t1   = fup_t1;
                st_d.pair_t2   = st_q.pend_ts;
                st_d.pair_corr = st_q.pend_corr + fup_corr;
                st_d.pair_gap  = st_q.age;
                st_d.done_v    = 1'b1;
                st_d.done_seq  = st_q.pend_seq;
                st_d.done_port = st_q.pend_port;
            end else begin
                st_d.ev_mis  = 1'b1;
                st_d.ev_late = (fup_cls == FUP_LATE);
                st_d.ev_dup  = (fup_cls == FUP_DUP);
            end
        end

        // window closes when age reaches the programmed limit
        if (st_q.pend_v && !matched && (st_q.age >= timeout_cycles)) begin
            expired       = 1'b1;
            st_d.pend_v   = 1'b0;
            st_d.ev_tmo   = 1'b1;
            st_d.exp_v    = 1'b1;
            st_d.exp_seq  = st_q.pend_seq;
            st_d.exp_port = st_q.pend_port;
        end

        if (sync_valid) begin
            st_d.ev_lost   = st_q.pend_v && !matched && !expired;
            st_d.pend_v    = 1'b1;
            st_d.pend_seq  = sync_seq;
            st_d.pend_port = sync_port;
            st_d.pend_ts   = sync_ts;
            st_d.pend_corr = sync_corr;
            st_d.age       = {{(TMO_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_v    = st_q.pend_v;
    assign pend_seq  = st_q.pend_seq;
    assign pend_port = st_q.pend_port;
    assign exp_v     = st_q.exp_v;
    assign exp_seq   = st_q.exp_seq;
    assign exp_port  = st_q.exp_port;
    assign done_v    = st_q.done_v;
    assign done_seq  = st_q.done_seq;
    assign done_port = st_q.done_port;
    assign pair_v    = st_q.pair_v;
    assign pair_seq  = st_q.pair_seq;
    assign pair_t1   = st_q.pair_t1;
    assign pair_t2   = st_q.pair_t2;
    assign pair_corr = st_q.pair_corr;
    assign pair_gap  = st_q.pair_gap;
    assign ev_lost   = st_q.ev_lost;
    assign ev_tmo    = st_q.ev_tmo;
    assign ev_mis    = st_q.ev_mis;
    assign ev_late   = st_q.ev_late;
    assign ev_dup    = st_q.ev_dup;

endmodule

// File: rtl/sfp_stats.sv
module sfp_stats
    import sfp_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int TMO_W = 24,
    parameter int CNT_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ev_lost,
    input  logic                          ev_tmo,
    input  logic                          ev_mis,
    input  logic                          pair_v,
    input  logic [SEQ_W-1:0]              pair_seq,
    input  logic [TMO_W-1:0]              pair_gap,
    output logic [NUM_EV-1:0][CNT_W-1:0]  cnt,
    output logic [TMO_W-1:0]              max_gap
);

    typedef struct packed {
        logic             prev_v;
        logic [SEQ_W-1:0] prev_seq;
        logic [TMO_W-1:0] max_gap;
    } trk_t;

    trk_t              trk_d, trk_q;
    logic              disc;
    logic [NUM_EV-1:0] ev;

    always_comb begin
        trk_d = trk_q;
        disc  = 1'b0;
        if (pair_v) begin
            disc           = trk_q.prev_v && (pair_seq != trk_q.prev_seq + 1'b1);
            trk_d.prev_v   = 1'b1;
            trk_d.prev_seq = pair_seq;
            if (pair_gap > trk_q.max_gap) begin
                trk_d.max_gap = pair_gap;
            end
        end
        ev          = '0;
        ev[EV_LOST] = ev_lost;
        ev[EV_TMO]  = ev_tmo;
        ev[EV_MIS]  = ev_mis;
        ev[EV_DISC] = disc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    // one saturating counter per event lane
    for (genvar i = 0; i < NUM_EV; i++) begin : g_cnt
        logic [CNT_W-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (ev[i] && (cnt_q != {CNT_W{1'b1}})) begin
                cnt_d = cnt_q + 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_d;
            end
        end

        assign cnt[i] = cnt_q;
    end

    assign max_gap = trk_q.max_gap;

endmodule

// File: rtl/ptp_fup_pairer.sv
module ptp_fup_pairer
    import sfp_pkg::*;
#(
    parameter int SEQ_W  = 16,
    parameter int PORT_W = 80,
    parameter int TS_W   = 80,
    parameter int CORR_W = 64,
    parameter int TMO_W  = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMO_W-1:0]  timeout_cycles,
    input  logic              sync_valid,
    input  logic [SEQ_W-1:0]  sync_seq,
    input  logic [PORT_W-1:0] sync_port,
    input  logic [TS_W-1:0]   sync_ts,
    input  logic [CORR_W-1:0] sync_corr,
    input  logic              fup_valid,
    input  logic [SEQ_W-1:0]  fup_seq,
    input  logic [PORT_W-1:0] fup_port,
    input  logic [TS_W-1:0]   fup_t1,
    input  logic [CORR_W-1:0] fup_corr,
    output logic              pair_valid,
    output logic [SEQ_W-1:0]  pair_seq,
    output logic [TS_W-1:0]   pair_t1,
    output logic [TS_W-1:0]   pair_t2,
    output logic [CORR_W-1:0] pair_corr,
    output logic [TMO_W-1:0]  pair_gap,
    output logic              pending,
    output logic              evt_lost,
    output logic              evt_timeout,
    output logic              evt_mismatch,
    output logic              evt_late,
    output logic              evt_dup,
    output logic [CNT_W-1:0]  lost_cnt,
    output logic [CNT_W-1:0]  timeout_cnt,
    output logic [CNT_W-1:0]  mismatch_cnt,
    output logic [CNT_W-1:0]  discont_cnt,
    output logic [TMO_W-1:0]  max_gap
);

    fup_class_e                 cls;
    logic                       pend_v, exp_v, done_v;
    logic [SEQ_W-1:0]           pend_seq, exp_seq, done_seq;
    logic [PORT_W-1:0]          pend_port, exp_port, done_port;
    logic [NUM_EV-1:0][CNT_W-1:0] cnt;

    sfp_classify #(.SEQ_W(SEQ_W), .PORT_W(PORT_W)) u_cls (
        .fup_seq   (fup_seq),
        .fup_port  (fup_port),
        .pend_v    (pend_v),
        .pend_seq  (pend_seq),
        .pend_port (pend_port),
        .exp_v     (exp_v),
        .exp_seq   (exp_seq),
        .exp_port  (exp_port),
        .done_v    (done_v),
        .done_seq  (done_seq),
        .done_port (done_port),
        .cls       (cls)
    );

    sfp_slot #(
        .SEQ_W(SEQ_W), .PORT_W(PORT_W), .TS_W(TS_W),
        .CORR_W(CORR_W), .TMO_W(TMO_W)
    ) u_slot (
        .clk            (clk),
        .rst_n          (rst_n),
        .timeout_cycles (timeout_cycles),
        .sync_valid     (sync_valid),
        .sync_seq       (sync_seq),
        .sync_port      (sync_port),
        .sync_ts        (sync_ts),
        .sync_corr      (sync_corr),
        .fup_valid      (fup_valid),
        .fup_t1         (fup_t1),
        .fup_corr       (fup_corr),
        .fup_cls        (cls),
        .pend_v         (pend_v),
        .pend_seq       (pend_seq),
        .pend_port      (pend_port),
        .exp_v          (exp_v),
        .exp_seq        (exp_seq),
        .exp_port       (exp_port),
        .done_v         (done_v),
        .done_seq       (done_seq),
        .done_port      (done_port),
        .pair_v         (pair_valid),
        .pair_seq       (pair_seq),
        .pair_t1        (pair_t1),
        .pair_t2        (pair_t2),
        .pair_corr      (pair_corr),
        .pair_gap       (pair_gap),
        .ev_lost        (evt_lost),
        .ev_tmo         (evt_timeout),
        .ev_mis         (evt_mismatch),
        .ev_late        (evt_late),
        .ev_dup         (evt_dup)
    );

    sfp_stats #(.SEQ_W(SEQ_W), .TMO_W(TMO_W), .CNT_W(CNT_W)) u_stats (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_lost  (evt_lost),
        .ev_tmo   (evt_timeout),
        .ev_mis   (evt_mismatch),
        .pair_v   (pair_valid),
        .pair_seq (pair_seq),
        .pair_gap (pair_gap),
        .cnt      (cnt),
        .max_gap  (max_gap)
    );

    assign pending      = pend_v;
    assign lost_cnt     = cnt[EV_LOST];
    assign timeout_cnt  = cnt[EV_TMO];
    assign mismatch_cnt = cnt[EV_MIS];
    assign discont_cnt  = cnt[EV_DISC];

endmodule

// File: rtl/ptp_fup_pairer_chk.sv
module ptp_fup_pairer_chk #(
    parameter int SEQ_W = 16,
    parameter int TMO_W = 24,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TMO_W-1:0] timeout_cycles,
    input logic             fup_valid,
    input logic [SEQ_W-1:0] fup_seq,
    input logic             pair_valid,
    input logic [SEQ_W-1:0] pair_seq,
    input logic [TMO_W-1:0] pair_gap,
    input logic             pending,
    input logic             evt_lost,
    input logic             evt_mismatch,
    input logic             evt_late,
    input logic             evt_dup,
    input logic [CNT_W-1:0] lost_cnt,
    input logic [CNT_W-1:0] mismatch_cnt,
    input logic [TMO_W-1:0] max_gap
);

    assert_pair_from_fup_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> ($past(fup_valid) && ($past(fup_seq) == pair_seq)));

    assert_pair_needs_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> $past(pending));

    assert_pair_or_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(pair_valid && evt_mismatch));

    assert_drop_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_late || evt_dup) |-> (evt_mismatch && $onehot0({evt_late, evt_dup})));

    assert_mismatch_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_cnt >= $past(mismatch_cnt));

    assert_lost_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_lost |=> ((lost_cnt == $past(lost_cnt) + 1'b1) || ($past(lost_cnt) == {CNT_W{1'b1}})));

    assert_gap_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> ((pair_gap != '0) && (pair_gap <= $past(timeout_cycles))));

    assert_max_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> (max_gap >= $past(pair_gap)));

endmodule

bind ptp_fup_pairer ptp_fup_pairer_chk #(
    .SEQ_W(SEQ_W), .TMO_W(TMO_W), .CNT_W(CNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .timeout_cycles (timeout_cycles),
    .fup_valid      (fup_valid),
    .fup_seq        (fup_seq),
    .pair_valid     (pair_valid),
    .pair_seq       (pair_seq),
    .pair_gap       (pair_gap),
    .pending        (pending),
    .evt_lost       (evt_lost),
    .evt_mismatch   (evt_mismatch),
    .evt_late       (evt_late),
    .evt_dup        (evt_dup),
    .lost_cnt       (lost_cnt),
    .mismatch_cnt   (mismatch_cnt),
    .max_gap        (max_gap)
);

// File: tb/ptp_fup_pairer_tb.sv
module ptp_fup_pairer_tb;

    localparam int SEQ_W  = 16;
    localparam int PORT_W = 80;
    localparam int TS_W   = 80;
    localparam int CORR_W = 64;
    localparam int TMO_W  = 24;
    localparam int CNT_W  = 16;
    localparam int WINDOW = 20;

    localparam logic [PORT_W-1:0] PORT_A = 80'h0011_2233_4455_6677_0001;
    localparam logic [PORT_W-1:0] PORT_B = 80'h0011_2233_4455_6677_0002;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TMO_W-1:0]  timeout_cycles = TMO_W'(WINDOW);
    logic              sync_valid = 1'b0;
    logic [SEQ_W-1:0]  sync_seq = '0;
    logic [PORT_W-1:0] sync_port = '0;
    logic [TS_W-1:0]   sync_ts = '0;
    logic [CORR_W-1:0] sync_corr = '0;
    logic              fup_valid = 1'b0;
    logic [SEQ_W-1:0]  fup_seq = '0;
    logic [PORT_W-1:0] fup_port = '0;
    logic [TS_W-1:0]   fup_t1 = '0;
    logic [CORR_W-1:0] fup_corr = '0;
    logic              pair_valid, pending;
    logic [SEQ_W-1:0]  pair_seq;
    logic [TS_W-1:0]   pair_t1, pair_t2;
    logic [CORR_W-1:0] pair_corr;
    logic [TMO_W-1:0]  pair_gap, max_gap;
    logic              evt_lost, evt_timeout, evt_mismatch, evt_late, evt_dup;
    logic [CNT_W-1:0]  lost_cnt, timeout_cnt, mismatch_cnt, discont_cnt;

    always #5 clk = ~clk;

    ptp_fup_pairer #(
        .SEQ_W(SEQ_W), .PORT_W(PORT_W), .TS_W(TS_W),
        .CORR_W(CORR_W), .TMO_W(TMO_W), .CNT_W(CNT_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .timeout_cycles(timeout_cycles),
        .sync_valid(sync_valid), .sync_seq(sync_seq), .sync_port(sync_port),
        .sync_ts(sync_ts), .sync_corr(sync_corr),
        .fup_valid(fup_valid), .fup_seq(fup_seq), .fup_port(fup_port),
        .fup_t1(fup_t1), .fup_corr(fup_corr),
        .pair_valid(pair_valid), .pair_seq(pair_seq), .pair_t1(pair_t1),
        .pair_t2(pair_t2), .pair_corr(pair_corr), .pair_gap(pair_gap),
        .pending(pending), .evt_lost(evt_lost), .evt_timeout(evt_timeout),
        .evt_mismatch(evt_mismatch), .evt_late(evt_late), .evt_dup(evt_dup),
        .lost_cnt(lost_cnt), .timeout_cnt(timeout_cnt),
        .mismatch_cnt(mismatch_cnt), .discont_cnt(discont_cnt), .max_gap(max_gap)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // expected state kept by the bench
    int            e_lost = 0, e_tmo = 0, e_mis = 0, e_disc = 0, e_max = 0;
    logic          have_prev = 1'b0;
    logic [15:0]   prev_seq = '0;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        sync_valid = 1'b0;
        fup_valid  = 1'b0;
    endtask

    task automatic put_sync(input logic [15:0] s, input logic [PORT_W-1:0] p,
                            input logic [TS_W-1:0] t, input logic [CORR_W-1:0] c);
        sync_valid = 1'b1; sync_seq = s; sync_port = p; sync_ts = t; sync_corr = c;
    endtask

    task automatic put_fup(input logic [15:0] s, input logic [PORT_W-1:0] p,
                           input logic [TS_W-1:0] t, input logic [CORR_W-1:0] c);
        fup_valid = 1'b1; fup_seq = s; fup_port = p; fup_t1 = t; fup_corr = c;
    endtask

    // expected continuity bookkeeping on a pair
    task automatic note_pair(input logic [15:0] s, input int gap);
        if (have_prev && (s != prev_seq + 16'd1)) e_disc++;
        have_prev = 1'b1;
        prev_seq  = s;
        if (gap > e_max) e_max = gap;
    endtask

    task automatic chk_counts(input string tag);
        chk({tag, " R4 lost_cnt"},     128'(lost_cnt),     128'(e_lost));
        chk({tag, " R5 timeout_cnt"},  128'(timeout_cnt),  128'(e_tmo));
        chk({tag, " R3 mismatch_cnt"}, 128'(mismatch_cnt), 128'(e_mis));
        chk({tag, " R7 discont_cnt"},  128'(discont_cnt),  128'(e_disc));
        chk({tag, " R6 max_gap"},      128'(max_gap),      128'(e_max));
    endtask

    typedef struct packed {
        logic [15:0] sseq;
        logic [15:0] fseq;
        logic        fport_b;
        logic [7:0]  dly;
        logic        exp_pair;
        logic        exp_late;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [0:NVEC-1] = '{
        '{16'd10, 16'd10, 1'b0, 8'd3,  1'b1, 1'b0},  // first pair
        '{16'd11, 16'd11, 1'b0, 8'd1,  1'b1, 1'b0},  // shortest gap
        '{16'd12, 16'd12, 1'b1, 8'd4,  1'b0, 1'b0},  // port differs
        '{16'd13, 16'd99, 1'b0, 8'd2,  1'b0, 1'b0},  // sequence differs
        '{16'd15, 16'd15, 1'b0, 8'd20, 1'b1, 1'b0},  // gap equals window, seq jump
        '{16'd16, 16'd16, 1'b0, 8'd21, 1'b0, 1'b1},  // one past window: late
        '{16'd17, 16'd17, 1'b0, 8'd5,  1'b1, 1'b0}   // resume
    };

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 pending", 128'(pending), 128'd0);
        chk("R9 pair_valid", 128'(pair_valid), 128'd0);
        chk("R9 flags", 128'({evt_lost, evt_timeout, evt_mismatch, evt_late, evt_dup}), 128'd0);
        chk_counts("R9 reset");
        rst_n = 1'b1;
        step();

        for (int i = 0; i < NVEC; i++) begin
            logic [TS_W-1:0]   t2, t1;
            logic [CORR_W-1:0] c1, c2;
            logic [PORT_W-1:0] fp;
            t2 = TS_W'(VEC[i].sseq) * 80'd3 + 80'h1_0000_0000;
            t1 = TS_W'(VEC[i].sseq) + 80'd1000;
            c1 = CORR_W'(VEC[i].sseq) << 16;
            c2 = 64'd5 << 16;
            fp = VEC[i].fport_b ? PORT_B : PORT_A;
            put_sync(VEC[i].sseq, PORT_A, t2, c1);
            step();
            repeat (int'(VEC[i].dly) - 1) step();
            put_fup(VEC[i].fseq, fp, t1, c2);
            step();
            if (VEC[i].exp_pair) begin
                chk("R1 pair_valid", 128'(pair_valid), 128'd1);
                chk("R1 pair_seq", 128'(pair_seq), 128'(VEC[i].sseq));
                chk("R1 pair_t1", 128'(pair_t1), 128'(t1));
                chk("R1 pair_t2", 128'(pair_t2), 128'(t2));
                chk("R2 pair_corr", 128'(pair_corr), 128'(c1 + c2));
                chk("R6 pair_gap", 128'(pair_gap), 128'(VEC[i].dly));
                note_pair(VEC[i].sseq, int'(VEC[i].dly));
            end else begin
                chk("R3 no pair", 128'(pair_valid), 128'd0);
                chk("R3 evt_mismatch", 128'(evt_mismatch), 128'd1);
                chk("R3 evt_late", 128'(evt_late), 128'(VEC[i].exp_late));
                e_mis++;
                e_tmo++;   // held Sync expires inside the idle wait (R5)
            end
            repeat (25) step();
            chk("R5 pending cleared", 128'(pending), 128'd0);
            chk_counts("table");
        end

        // R4: overwrite a pending Sync
        put_sync(16'd30, PORT_A, 80'd300, 64'd0);
        step();
        put_sync(16'd31, PORT_A, 80'd310, 64'd0);
        step();
        chk("R4 evt_lost", 128'(evt_lost), 128'd1);
        e_lost++;
        put_fup(16'd31, PORT_A, 80'd311, 64'd0);
        step();
        chk("R4 survivor pairs", 128'(pair_seq), 128'd31);
        chk("R4 survivor t2", 128'(pair_t2), 128'd310);
        note_pair(16'd31, 1);

        // R3: repeat of the last paired Follow_Up
        put_fup(16'd31, PORT_A, 80'd311, 64'd0);
        step();
        chk("R3 dup no pair", 128'(pair_valid), 128'd0);
        chk("R3 evt_dup", 128'(evt_dup), 128'd1);
        e_mis++;

        // R8: Follow_Up and new Sync on the same edge
        put_sync(16'd40, PORT_A, 80'd400, 64'd0);
        step();
        put_fup(16'd40, PORT_A, 80'd401, 64'd0);
        put_sync(16'd41, PORT_A, 80'd410, 64'd0);
        step();
        chk("R8 old Sync pairs", 128'({pair_valid, pair_seq}), 128'({1'b1, 16'd40}));
        chk("R8 no loss", 128'(evt_lost), 128'd0);
        chk("R8 new Sync held", 128'(pending), 128'd1);
        note_pair(16'd40, 1);
        put_fup(16'd41, PORT_A, 80'd411, 64'd0);
        step();
        chk("R8 new Sync pairs", 128'({pair_valid, pair_seq}), 128'({1'b1, 16'd41}));
        note_pair(16'd41, 1);

        // R2 carry out of 64 bits, R7 wrap from 65535 to 0
        put_sync(16'hFFFF, PORT_A, 80'd500, 64'hFFFF_FFFF_0000_0000);
        step();
        put_fup(16'hFFFF, PORT_A, 80'd501, 64'h0000_0001_0000_0000);
        step();
        chk("R2 corr wraps", 128'(pair_corr), 128'd0);
        note_pair(16'hFFFF, 1);
        put_sync(16'd0, PORT_A, 80'd600, 64'd0);
        step();
        put_fup(16'd0, PORT_A, 80'd601, 64'd0);
        step();
        chk("R7 wrap pair", 128'({pair_valid, pair_seq}), 128'({1'b1, 16'd0}));
        note_pair(16'd0, 1);
        repeat (3) step();
        chk_counts("directed");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule